// File: doc/BRIEF.md
# Byte Serializer/Deserializer with Loopback Paths

This block is the byte-wide datapath of an optical line transceiver. On the transmit side it takes one 8-bit word every eight bit clocks and sends it out one bit per clock, most significant bit first. On the receive side it shifts the serial line into a register and presents a new parallel word every eight receive clocks. Alongside the words it provides a receive byte clock at one eighth of the receive bit rate.

Two test paths can be switched in. Line-side loopback returns the received serial data and the receive clock straight to the transmit pins, while the receiver keeps producing words. Host-side loopback routes the serializer output into the deserializer instead of the line input. Both paths may be enabled together.

A loss-of-signal flag is formed from an optics signal-detect input and a polarity input. The flag is the XNOR of the two. While the flag is set, the parallel receive word is forced to zero. Byte alignment is not searched for: a free-running bit counter, cleared by reset, sets the word boundary.

Top module: `byte_serdes_lb`

## Requirements
- R1: After reset is released, `tx_word` is sampled on the first `tx_clk` edge and then on every 8th edge. Each sampled word is shifted out on `tx_ser_out` one bit per `tx_clk`, with bit 7 first. While reset is held and `fac_lb` is 0, `tx_ser_out` is 0.
- R2: The receiver shifts one bit in on every `rx_clk` edge. On the 8th edge after reset release, and on every 8th edge after that, `rx_word` takes the last eight received bits. The earliest of those bits lands in bit 7.
- R3: `rx_byte_clk` is 1 in reset and for four receive bit periods, then 0 for four. It rises on the same `rx_clk` edge that updates `rx_word`.
- R4: While `fac_lb` is 1, `tx_ser_out` follows `rx_ser_in` and `tx_clk_out` follows `rx_clk`. Deserialization of `rx_ser_in` continues. While `fac_lb` is 0, `tx_clk_out` follows `tx_clk`.
- R5: While `eq_lb` is 1, the deserializer takes its bits from the serializer output instead of `rx_ser_in`. If `fac_lb` is 0, `tx_ser_out` still carries the serializer output.
- R6: With `fac_lb` and `eq_lb` both 1, both loop paths act at the same time: `rx_ser_in` drives `tx_ser_out`, and the serializer drives the deserializer.
- R7: `los_out` equals `sd_in` XNOR `sd_pol`, so it is 1 when the two inputs are equal. The two inputs are interchangeable.
- R8: While `los_out` is 1, `rx_word` reads all zeros. Word capture goes on underneath, and the captured word reappears when `los_out` returns to 0.
- R9: A synchronous active-high `rst` clears both shift registers and both bit counters in their own clock domains.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tx_clk | input | 1 | Transmit bit clock |
| rx_clk | input | 1 | Receive bit clock |
| rst | input | 1 | Synchronous active-high reset, applied in both domains |
| tx_word | input | 8 | Parallel transmit word |
| rx_ser_in | input | 1 | Serial receive data |
| sd_in | input | 1 | Signal detect from the optics |
| sd_pol | input | 1 | Polarity select for the signal detect |
| fac_lb | input | 1 | Line-side loopback enable |
| eq_lb | input | 1 | Host-side loopback enable |
| tx_ser_out | output | 1 | Serial transmit data |
| tx_clk_out | output | 1 | Transmit clock output |
| rx_word | output | 8 | Parallel receive word |
| rx_byte_clk | output | 1 | Receive clock divided by 8 |
| los_out | output | 1 | Loss-of-signal flag |

## Verification
The bench changes `tx_word` on every clock, not only once per word. A serializer that samples on the wrong count therefore sends bits from a neighbouring word. A design that shifts LSB first shows the same kind of bit-order mismatch on the very first word.

The receive clock runs a quarter period after the transmit clock. This exposes a host-side loopback that takes its bits from the wrong point, or a word boundary that is off by one: either one rotates every captured word. It also lets the clock-output multiplexer be seen at a moment when the two clocks differ.

Loopback modes, reset pulses and all four signal-detect combinations are mixed at random. A design that inverts the polarity rule, or that blanks the word by clearing its holding register, shows a wrong word once the loss condition clears.

// File: rtl/byte_serdes_lb.sv
module byte_serdes_lb #(
  parameter int W = 8
) (
  input  logic         tx_clk,
  input  logic         rx_clk,
  input  logic         rst,
  input  logic [W-1:0] tx_word,
  input  logic         rx_ser_in,
  input  logic         sd_in,
  input  logic         sd_pol,
  input  logic         fac_lb,
  input  logic         eq_lb,
  output logic         tx_ser_out,
  output logic         tx_clk_out,
  output logic [W-1:0] rx_word,
  output logic         rx_byte_clk,
  output logic         los_out
);
  localparam int CW = $clog2(W);
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  logic [CW-1:0] tx_cnt, rx_cnt;
  logic [W-1:0]  tx_sh, rx_sh, rx_hold;
  logic          tx_bit, rx_src;

  assign tx_bit = tx_sh[W-1];
  assign rx_src = eq_lb ? tx_bit : rx_ser_in;

  always_ff @(posedge tx_clk) begin
    if (rst) begin
      tx_cnt <= '0;
      tx_sh  <= '0;
    end else begin
      tx_cnt <= tx_cnt + CW'(1);
      tx_sh  <= (tx_cnt == '0) ? tx_word : {tx_sh[W-2:0], 1'b0};
    end
  end

  always_ff @(posedge rx_clk) begin
    if (rst) begin
      rx_cnt  <= '0;
      rx_sh   <= '0;
      rx_hold <= '0;
    end else begin
      rx_cnt <= rx_cnt + CW'(1);
      rx_sh  <= {rx_sh[W-2:0], rx_src};
      if (rx_cnt == LAST) rx_hold <= {rx_sh[W-2:0], rx_src};
    end
  end

  assign los_out     = ~(sd_in ^ sd_pol);
  assign rx_word     = los_out ? '0 : rx_hold;
  assign rx_byte_clk = ~rx_cnt[CW-1];
  assign tx_ser_out  = fac_lb ? rx_ser_in : tx_bit;
  assign tx_clk_out  = fac_lb ? rx_clk : tx_clk;
endmodule

// File: rtl/byte_serdes_lb_chk.sv
module byte_serdes_lb_chk #(
  parameter int W = 8,
  localparam int CW = $clog2(W)
) (
  input logic          tx_clk,
  input logic          rx_clk,
  input logic          rst,
  input logic          fac_lb,
  input logic [W-1:0]  tx_word,
  input logic [W-1:0]  tx_sh,
  input logic [CW-1:0] tx_cnt,
  input logic          tx_ser_out,
  input logic [W-1:0]  rx_word,
  input logic          rx_byte_clk,
  input logic          los_out
);
  AST_TX_LOAD_MSB: assert property (@(posedge tx_clk) disable iff (rst)
    (!fac_lb && tx_cnt == CW'(1)) |-> tx_ser_out == $past(tx_word[W-1])); // R1

  AST_TX_SHIFT: assert property (@(posedge tx_clk) disable iff (rst)
    (!fac_lb && tx_cnt != CW'(1) && $past(!rst)) |-> tx_ser_out == $past(tx_sh[W-2])); // R1

  AST_WORD_ON_BYTECLK: assert property (@(posedge rx_clk) disable iff (rst)
    (!$stable(rx_word) && $stable(los_out)) |-> $rose(rx_byte_clk)); // R3

  AST_BYTECLK_HOLD: assert property (@(posedge rx_clk) disable iff (rst)
    $rose(rx_byte_clk) |=> rx_byte_clk); // R3

  AST_LOS_BLANK: assert property (@(posedge rx_clk) disable iff (rst)
    los_out |-> rx_word == '0); // R8
endmodule

bind byte_serdes_lb byte_serdes_lb_chk #(.W(W)) chk_i (
  .tx_clk(tx_clk), .rx_clk(rx_clk), .rst(rst), .fac_lb(fac_lb),
  .tx_word(tx_word), .tx_sh(tx_sh), .tx_cnt(tx_cnt), .tx_ser_out(tx_ser_out),
  .rx_word(rx_word), .rx_byte_clk(rx_byte_clk), .los_out(los_out)
);

// File: tb/byte_serdes_lb_tb_top.sv
module byte_serdes_lb_tb_top;
  logic clk = 1'b0, rx_clk = 1'b0, rst = 1'b1;
  logic [7:0] tx_word = '0;
  logic rx_ser_in = 0, sd_in = 0, sd_pol = 1, fac_lb = 0, eq_lb = 0;
  logic tx_ser_out, tx_clk_out, rx_byte_clk, los_out;
  logic [7:0] rx_word;
  int checks = 0, errs = 0;
  bit done = 0;

  always #10 clk = ~clk;
  initial begin #5; forever begin rx_clk = ~rx_clk; #10; end end

  byte_serdes_lb dut_i (
    .tx_clk(clk), .rx_clk(rx_clk), .rst(rst), .tx_word(tx_word),
    .rx_ser_in(rx_ser_in), .sd_in(sd_in), .sd_pol(sd_pol),
    .fac_lb(fac_lb), .eq_lb(eq_lb), .tx_ser_out(tx_ser_out),
    .tx_clk_out(tx_clk_out), .rx_word(rx_word),
    .rx_byte_clk(rx_byte_clk), .los_out(los_out)
  );

  logic [2:0] m_tc = 0, m_rc = 0;
  logic [7:0] m_ts = 0, m_rs = 0, m_rh = 0;

  always @(posedge clk)
    if (rst) begin m_tc <= 0; m_ts <= 0; end
    else begin
      m_tc <= m_tc + 3'd1;
      m_ts <= (m_tc == 0) ? tx_word : {m_ts[6:0], 1'b0};
    end

  always @(posedge rx_clk) begin : rxm
    logic b;
    b = eq_lb ? m_ts[7] : rx_ser_in;
    if (rst) begin m_rc <= 0; m_rs <= 0; m_rh <= 0; end
    else begin
      m_rc <= m_rc + 3'd1;
      m_rs <= {m_rs[6:0], b};
      if (m_rc == 3'd7) m_rh <= {m_rs[6:0], b};
    end
  end

  function automatic logic exp_los(logic a, logic b);
    return a == b;
  endfunction

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(negedge clk); #1;
  endtask

  task automatic look();
    string tt, rt;
    logic l;
    #7;
    l = exp_los(sd_in, sd_pol);
    tt = fac_lb ? (eq_lb ? "R6" : "R4") : "R1";
    rt = l ? "R8" : eq_lb ? (fac_lb ? "R6" : "R5") : (fac_lb ? "R4" : "R2");
    chk(tt, {7'd0, tx_ser_out}, {7'd0, fac_lb ? rx_ser_in : m_ts[7]});
    chk(rt, rx_word, l ? 8'h00 : m_rh);
    chk("R3", {7'd0, rx_byte_clk}, {7'd0, m_rc < 3'd4});
    chk("R7", {7'd0, los_out}, {7'd0, l});
    chk("R4", {7'd0, tx_clk_out}, {7'd0, fac_lb});
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      errs++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    tick(); tick();
    tx_word = 8'hA5; rx_ser_in = 1;
    tick(); #7;
    chk("R9", {7'd0, tx_ser_out}, 8'd0);
    chk("R9", rx_word, 8'h00);
    chk("R9", {7'd0, rx_byte_clk}, 8'd1);
    rst = 0;
    tx_word = 8'hC3;
    for (int i = 0; i < 9; i++) begin tick(); look(); end
    for (int k = 0; k < 4; k++) begin
      tick(); sd_in = k[0]; sd_pol = k[1]; look();
      chk("R7", {7'd0, los_out}, {7'd0, k[0] == k[1]});
    end
    for (int s = 0; s < 300; s++) begin
      logic [31:0] r;
      r = $urandom;
      for (int c = 0; c < 8; c++) begin
        tick();
        if (c == 0) begin
          fac_lb = r[0]; eq_lb = r[1];
          sd_pol = r[4];
          sd_in  = (r[3:2] == 2'b00) ? r[4] : ~r[4];
          rst    = (s % 25 == 24);
        end else rst = 0;
        tx_word   = 8'($urandom);
        rx_ser_in = 1'($urandom);
        look();
      end
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule